// File: doc/BRIEF.md
# Low-Order Interleaved Burst Read Memory

This block is a word-addressed memory split across several banks. The low bits of each word address pick the bank and the high bits pick the row inside that bank. As a result, neighbouring addresses sit side by side in different banks. A read burst is set up with a start address and a word count, then launched with a one-cycle start pulse. The block then returns the words in address order on a streaming output, one per cycle, with a valid flag.

For each row it needs, the block sends a single row address to every bank at once. Each bank is a storage array that delivers its word a fixed number of cycles after the request and accepts nothing new while it is busy. When a row is ready, all bank results are captured together into per-bank holding registers. Those registers are then drained one word per cycle. While one row drains, the request for the following row is already in flight, so the output keeps pace with the clock whenever there are at least as many banks as cycles of bank latency.

Writes use a separate single-word port that updates exactly one bank location per cycle.

Top module: `ilv_burst_reader`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in bank `wr_addr[BANK_BITS-1:0]` at row `wr_addr[ADDR_W-1:BANK_BITS]`. No other address changes, and a later burst returns the new value only at that address.
- R2: A burst returns the words at `start_addr`, `start_addr+1`, and so on, modulo 2^ADDR_W. The bank index rises by one per word and the row advances by one whenever the bank index wraps from its highest value to 0.
- R3: If `start` is sampled high at clock edge E, the word at offset k of the burst is presented (`rd_valid` high, `rd_data` valid) after edge E + b + k + LATENCY + 2, where b = `start_addr[BANK_BITS-1:0]`. The banks of the first row below b produce no output slot.
- R4: `rd_valid` is high for exactly `burst_len` consecutive cycles per accepted burst, with no gap, and is low at all other times.
- R5: After a burst is accepted at edge E, a start pulse at any edge up to and including E + 2^BANK_BITS * ceil((b + `burst_len`) / 2^BANK_BITS) is ignored. The output stream is then exactly that of the original burst.
- R6: A start pulse with `burst_len` equal to 0 produces no output and starts nothing.
- R7: While `rst_n` is low at a clock edge, `rd_valid` is low after that edge and any burst in progress is dropped. Stored data is kept.
- R8: Each row fetch drives one shared row address to all banks in the same cycle. No bank gets a new request before its previous one has completed. The bank count must be at least LATENCY, which is checked at elaboration. Under that condition, bursts spanning many rows stream without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data to write |
| start | input | 1 | One-cycle burst launch pulse |
| start_addr | input | ADDR_W | First word address of the burst |
| burst_len | input | LEN_W | Number of words in the burst |
| rd_valid | output | 1 | Output word valid |
| rd_data | output | DATA_W | Streamed output word |

## Verification
The bench targets three groups of cases.

The first is misaligned starts: bank 1 mid-row, the last bank of a row, and an address two words below the top of memory so the row wraps to zero. A design that skipped the wrong banks, or failed to advance or wrap the row, would emit shifted or repeated words.

The second is a 40-word burst across many rows. If the next row's request did not overlap draining of the current row, or if the holding registers were reloaded too early, this burst would show gaps or words from the wrong row. The same burst would also catch a latency that is off by one cycle, since every word would arrive out of place.

The third is the quiet cases: a start pulse in the middle of a running burst, a zero-length start, and a single write followed by a read of its neighbours. A design that honoured the extra pulse, emitted a phantom word, or wrote several banks would produce miscompares on the output stream.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved burst reader.
package ilv_pkg;

    // Phase of the row walker.
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

endpackage

// File: rtl/ilv_bank.sv
// One memory bank: a storage array with a fixed access time.
// A read request latches the addressed word and signals done LATENCY cycles
// after the request edge (done is visible after edge request+LATENCY-1).
// Assumes the requester never issues while a read is still pending, except
// in the very cycle the pending read completes. Storage has no reset.
module ilv_bank #(
    parameter int ROW_BITS = 4,
    parameter int DATA_W   = 8,
    parameter int LATENCY  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_issue,
    input  logic [ROW_BITS-1:0] rd_row,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_done
);
    localparam int DEPTH = 1 << ROW_BITS;
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY + 1) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pending_q;

    // Store one word from the write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row] <= wr_data;
        end
    end

    // Latch the requested word and count down the access time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            cnt_q     <= '0;
            pending_q <= 1'b0;
        end else if (rd_issue) begin
            data_q    <= mem[rd_row];
            cnt_q     <= CNT_W'(LATENCY - 1);
            pending_q <= 1'b1;
        end else begin
            if (rd_done) begin
                pending_q <= 1'b0;
            end
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign rd_done = pending_q && (cnt_q == '0);
    assign rd_data = data_q;

    // R8: a request only arrives when the bank is free or just finishing.
    p_issue_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> (!pending_q || rd_done));

    // R3: a completed read reports done for one cycle only.
    p_done_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_issue) |=> !rd_done);

endmodule

// File: rtl/ilv_walker.sv
// Burst sequencer. Walks word slots one per cycle, starting at bank 0 of the
// row holding the start address. Requests a row from all banks at every bank-0
// slot and tags the slots that carry burst words (lower banks of the first row
// are skipped). Tags are delayed LATENCY+1 cycles so each one reaches the
// output stage one edge after its row lands in the holding registers.
// Assumes burst_len is stable while start is high.
module ilv_walker
    import ilv_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 4,
    parameter int LEN_W     = 8,
    parameter int LATENCY   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [BANK_BITS+ROW_BITS-1:0] start_addr,
    input  logic [LEN_W-1:0]              burst_len,
    output logic                          issue,
    output logic [ROW_BITS-1:0]           issue_row,
    output logic                          emit_valid,
    output logic [BANK_BITS-1:0]          emit_bank
);
    localparam int ADDR_W = BANK_BITS + ROW_BITS;
    localparam int STAGES = LATENCY + 1;
    localparam logic [BANK_BITS-1:0] LAST_BANK = BANK_BITS'((1 << BANK_BITS) - 1);

    walk_state_e          state_q;
    logic [BANK_BITS-1:0] bank_q;
    logic [ROW_BITS-1:0]  row_q;
    logic [BANK_BITS-1:0] skip_q;
    logic [LEN_W-1:0]     rem_q;
    logic                 tag_valid;
    logic [LEN_W-1:0]     rem_next;
    logic                 run;

    logic                 dly_v [STAGES];
    logic [BANK_BITS-1:0] dly_b [STAGES];

    assign run       = (state_q == WALK_RUN);
    assign tag_valid = run && (skip_q == '0) && (rem_q != '0);
    assign rem_next  = rem_q - LEN_W'(tag_valid);
    assign issue     = run && (bank_q == '0);
    assign issue_row = row_q;

    // Accept a burst when idle and advance one slot per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            bank_q  <= '0;
            row_q   <= '0;
            skip_q  <= '0;
            rem_q   <= '0;
        end else if (!run) begin
            if (start && (burst_len != '0)) begin
                state_q <= WALK_RUN;
                bank_q  <= '0;
                row_q   <= start_addr[ADDR_W-1:BANK_BITS];
                skip_q  <= start_addr[BANK_BITS-1:0];
                rem_q   <= burst_len;
            end
        end else begin
            bank_q <= bank_q + BANK_BITS'(1);
            rem_q  <= rem_next;
            if (skip_q != '0) begin
                skip_q <= skip_q - BANK_BITS'(1);
            end
            if (bank_q == LAST_BANK) begin
                row_q <= row_q + ROW_BITS'(1);
                if (rem_next == '0) begin
                    state_q <= WALK_IDLE;
                end
            end
        end
    end

    // Delay line carrying slot tags towards the output stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_v[s] <= 1'b0;
                dly_b[s] <= '0;
            end else if (s == 0) begin
                dly_v[s] <= tag_valid;
                dly_b[s] <= bank_q;
            end else begin
                dly_v[s] <= dly_v[(s == 0) ? 0 : s - 1];
                dly_b[s] <= dly_b[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign emit_valid = dly_v[STAGES-1];
    assign emit_bank  = dly_b[STAGES-1];

    // R5: once running, the walker finishes the whole row before going idle.
    p_run_whole_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (bank_q != LAST_BANK)) |=> (state_q == WALK_RUN));

    // R2: leaving the top bank with words still due moves to the next row.
    p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (bank_q == LAST_BANK) && (rem_next != '0))
        |=> (row_q == ROW_BITS'($past(row_q) + ROW_BITS'(1))));

endmodule

// File: rtl/ilv_burst_reader.sv
// Top of the low-order interleaved burst read memory. Instantiates one bank
// per low-address value, fans a shared row address out to all of them, loads
// every bank result into its own holding register in the same cycle, and
// drains those registers through a registered output, one word per cycle.
// Assumes no write targets a row while that row's read is in flight.
module ilv_burst_reader #(
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 4,
    parameter int DATA_W    = 8,
    parameter int LEN_W     = 8,
    parameter int LATENCY   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [BANK_BITS+ROW_BITS-1:0] wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          start,
    input  logic [BANK_BITS+ROW_BITS-1:0] start_addr,
    input  logic [LEN_W-1:0]              burst_len,
    output logic                          rd_valid,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int ADDR_W = BANK_BITS + ROW_BITS;
    localparam int BANKS  = 1 << BANK_BITS;

    // R8: the banks must cover the access time to keep one word per cycle.
    if (BANKS < LATENCY) begin : g_bank_check
        $error("ilv_burst_reader: bank count below bank latency");
    end

    logic                              issue;
    logic [ROW_BITS-1:0]               issue_row;
    logic                              emit_valid;
    logic [BANK_BITS-1:0]              emit_bank;
    logic [BANKS-1:0][DATA_W-1:0]      bank_data;
    logic [BANKS-1:0]                  bank_done;
    logic [BANKS-1:0][DATA_W-1:0]      hold_q;

    ilv_walker #(
        .BANK_BITS (BANK_BITS),
        .ROW_BITS  (ROW_BITS),
        .LEN_W     (LEN_W),
        .LATENCY   (LATENCY)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .burst_len  (burst_len),
        .issue      (issue),
        .issue_row  (issue_row),
        .emit_valid (emit_valid),
        .emit_bank  (emit_bank)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic sel_wr;
        assign sel_wr = wr_en && (wr_addr[BANK_BITS-1:0] == BANK_BITS'(g));

        ilv_bank #(
            .ROW_BITS (ROW_BITS),
            .DATA_W   (DATA_W),
            .LATENCY  (LATENCY)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel_wr),
            .wr_row   (wr_addr[ADDR_W-1:BANK_BITS]),
            .wr_data  (wr_data),
            .rd_issue (issue),
            .rd_row   (issue_row),
            .rd_data  (bank_data[g]),
            .rd_done  (bank_done[g])
        );
    end

    // Capture each finished bank word into its holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            for (int i = 0; i < BANKS; i++) begin
                if (bank_done[i]) begin
                    hold_q[i] <= bank_data[i];
                end
            end
        end
    end

    // Drain one holding register per cycle onto the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= emit_valid;
            if (emit_valid) begin
                rd_data <= hold_q[emit_bank];
            end
        end
    end

    // R7: a reset cycle leaves the output idle.
    p_reset_quiet_r7: assert property (@(posedge clk)
        !rst_n |=> !rd_valid);

    // R8: all banks finish a shared row fetch in the same cycle.
    p_banks_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_done == '0) || (bank_done == '1));

endmodule

// File: tb/ilv_burst_reader_bench.sv
`timescale 1ns/1ps
module ilv_burst_reader_bench;
    localparam int BANK_BITS = 2;
    localparam int ROW_BITS  = 4;
    localparam int DATA_W    = 8;
    localparam int LEN_W     = 8;
    localparam int LATENCY   = 3;
    localparam int ADDR_W    = BANK_BITS + ROW_BITS;
    localparam int BANKS     = 1 << BANK_BITS;
    localparam int NWORDS    = 1 << ADDR_W;
    localparam int WATCHDOG  = 20000;

    typedef struct {
        int                cyc;
        logic [DATA_W-1:0] d;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  burst_len = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;

    int    edge_n = 0;
    int    ignore_until = 0;
    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R7";
    logic [DATA_W-1:0] ref_mem [NWORDS];
    exp_t  expq [$];

    ilv_burst_reader #(
        .BANK_BITS (BANK_BITS),
        .ROW_BITS  (ROW_BITS),
        .DATA_W    (DATA_W),
        .LEN_W     (LEN_W),
        .LATENCY   (LATENCY)
    ) u_ilv_burst_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .start      (start),
        .start_addr (start_addr),
        .burst_len  (burst_len),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    always #2.5 clk = ~clk;

    // Reference model: memory image and expected output schedule per edge.
    always @(posedge clk) begin
        edge_n++;
        if (!rst_n) begin
            expq.delete();
            ignore_until = 0;
        end else begin
            if (wr_en) ref_mem[wr_addr] = wr_data;
            if (start && burst_len != 0 && edge_n > ignore_until) begin
                int b;
                int nrows;
                exp_t e;
                b = int'(start_addr) % BANKS;
                nrows = (b + int'(burst_len) + BANKS - 1) / BANKS;
                for (int k = 0; k < int'(burst_len); k++) begin
                    e.cyc = edge_n + b + k + LATENCY + 2;
                    e.d   = ref_mem[(int'(start_addr) + k) % NWORDS];
                    expq.push_back(e);
                end
                ignore_until = edge_n + nrows * BANKS;
            end
        end
        if (edge_n > WATCHDOG) begin
            fails++;
            $display("FAIL R4 watchdog: cycles %0d expected < %0d", edge_n, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Compare the output against the model on every clock, away from the edge.
    always @(negedge clk) begin
        vectors++;
        if (expq.size() != 0 && expq[0].cyc == edge_n) begin
            if (rd_valid !== 1'b1 || rd_data !== expq[0].d) begin
                fails++;
                $display("FAIL %s cycle %0d: valid=%b data=%h expected valid=1 data=%h",
                         cur_req, edge_n, rd_valid, rd_data, expq[0].d);
            end
            void'(expq.pop_front());
        end else if (rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s cycle %0d: valid=%b expected valid=0",
                     cur_req, edge_n, rd_valid);
        end
    end

    task automatic write_word(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic launch(input int a, input int n);
        @(negedge clk);
        start      = 1'b1;
        start_addr = ADDR_W'(a);
        burst_len  = LEN_W'(n);
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R7: output idle through reset.
        cur_req = "R7";
        wait_cycles(4);
        rst_n = 1'b1;

        // R1: fill every address through the write port.
        cur_req = "R1";
        for (int a = 0; a < NWORDS; a++) write_word(a, (a * 37 + 11) & 8'hFF);
        wait_cycles(4);

        // R2 R3 R4: aligned start, two full rows.
        cur_req = "R2/R3/R4 aligned";
        launch(0, 8);
        wait_cycles(30);

        // R3: start in bank 1, lower bank of the first row skipped.
        cur_req = "R3/R4 mid-row";
        launch(5, 6);
        wait_cycles(30);

        // R3: start in the last bank, single word.
        cur_req = "R3/R4 last-bank";
        launch(3, 1);
        wait_cycles(30);

        // R2: row wraps from the top of memory to zero.
        cur_req = "R2 wrap";
        launch(62, 5);
        wait_cycles(30);

        // R5: second pulse while the first burst runs is ignored.
        cur_req = "R5 ignored start";
        launch(8, 12);
        wait_cycles(3);
        launch(40, 4);
        wait_cycles(8);
        launch(44, 2);
        wait_cycles(40);

        // R6: zero-length start produces nothing.
        cur_req = "R6 zero length";
        launch(20, 0);
        wait_cycles(30);

        // R1: one write touches one bank only; read it with its neighbours.
        cur_req = "R1 single write";
        write_word(9, 8'hA5);
        wait_cycles(2);
        launch(8, 4);
        wait_cycles(30);

        // R8: long burst across many rows streams without gaps.
        cur_req = "R8/R4 long burst";
        launch(17, 40);
        wait_cycles(80);

        // R7: reset during a burst drops it and keeps storage.
        cur_req = "R7 reset mid-burst";
        launch(0, 16);
        wait_cycles(6);
        rst_n = 1'b0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(20);
        cur_req = "R7 storage kept";
        launch(8, 4);
        wait_cycles(30);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule